// File: doc/BRIEF.md
# Three-Level Programmable Trigger Matrix

This block builds trigger decisions from 24 single-bit detector port signals through three stages of logic that software can configure. The first stage holds eight coincidence-count units. Each one counts how many of its selected ports are high and fires when that count meets a programmed threshold. The second stage holds eight OR units. Each one can select any port and any first-stage output. The third stage holds two AND units. Each one can select any port and any second-stage output.

Configuration words sit at fixed addresses on a simple write/read register port. A separate select word routes one of 30 trigger terms to a single front-panel trigger output. Every stage is registered once, so a decision that passes through all three stages appears three clock cycles after the port edge that caused it.

Top module: `trig_matrix`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, every configuration word reads 0 and `multiOut`, `orOut`, `andOut` and `fpTrig` are 0.
- R2: A write stores the full 32-bit word when `regAddr` is one of 0x50, 0x60–0x67, 0x68–0x6F or 0x70–0x71, and `regRdata` then returns the last value written to `regAddr`. Any other address reads 0, and writing to it changes no stored word.
- R3: Count unit k (address 0x60+k) uses bits [23:0] as a port mask, where bit i selects `portIn[i]`, and bits [31:24] as an unsigned threshold. One cycle after the ports are sampled, `multiOut[k]` is 1 exactly when the number of high selected ports is greater than or equal to the threshold.
- R4: A count unit whose threshold field is 0 keeps its output at 0 for any ports and any mask.
- R5: OR unit k (address 0x68+k) masks a 32-bit vector: bits [23:0] are `portIn` and bit 24+j is `multiOut[j]`. One cycle later, `orOut[k]` is the OR of the selected bits.
- R6: An OR unit with an all-zero word outputs 0.
- R7: AND unit k (address 0x70+k) masks a 32-bit vector: bits [23:0] are `portIn` and bit 24+j is `orOut[j]`. One cycle later, `andOut[k]` is 1 only when every selected bit is 1.
- R8: An AND unit with an all-zero word outputs 0, whatever its inputs are.
- R9: A port edge that propagates through a count unit, an OR unit and an AND unit reaches `multiOut` after 1 cycle, `orOut` after 2 cycles and `andOut` after 3 cycles.
- R10: The select word at 0x50 routes a term to `fpTrig` one cycle later. Codes 0–23 select `portIn[code]`, 24–25 select `multiOut[0..1]`, 26–27 select `orOut[0..1]` and 28–29 select `andOut[0..1]`. Any code of 30 or more gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portIn | input | 24 | Detector port signals, index order fixed by R3 |
| regWe | input | 1 | Write strobe for the configuration word at `regAddr` |
| regAddr | input | 8 | Configuration word address, used for both writes and reads |
| regWdata | input | 32 | Data to write |
| regRdata | output | 32 | Combinational read of the word at `regAddr` |
| multiOut | output | 8 | Outputs of the count units |
| orOut | output | 8 | Outputs of the OR units |
| andOut | output | 2 | Outputs of the AND units |
| fpTrig | output | 1 | Selected front-panel trigger term |

## Verification
Ports are driven with sparse, dense and fully random words, while random configuration writes arrive at the same time. This exercises count thresholds both below and above the number of set bits. It also separates a correct OR from an AND, because dense ports make both high and sparse ports make both low. Directed cases cover the exact-threshold boundary, ports outside the mask, the zero threshold and zero masks, and the three-cycle chain from a port to an AND output. They also cover select codes on both sides of the last valid term and a write to an unmapped address. A shadow model tracks all three stages cycle by cycle, so a stage that reads the wrong cycle of the stage below shows up as a mismatch.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NPORT  = 24;
  localparam int NMULTI = 8;
  localparam int NOR    = 8;
  localparam int NAND   = 2;
  localparam int NFP    = 2;              // units per stage visible on the trigger select
  localparam int REGW   = 32;
  localparam int ADDRW  = 8;
  localparam int THRW   = REGW - NPORT;
  localparam int NTERM  = NPORT + 3 * NFP;
  localparam int SELW   = $clog2(NTERM);

  localparam logic [ADDRW-1:0] ADDR_SEL   = 8'h50;
  localparam logic [ADDRW-1:0] ADDR_MULTI = 8'h60;
  localparam logic [ADDRW-1:0] ADDR_OR    = 8'h68;
  localparam logic [ADDRW-1:0] ADDR_AND   = 8'h70;

  typedef struct packed {
    logic [NMULTI-1:0][REGW-1:0] multiCfg;
    logic [NOR-1:0][REGW-1:0]    orCfg;
    logic [NAND-1:0][REGW-1:0]   andCfg;
    logic [REGW-1:0]             selCfg;
  } trigCfg_t;

  function automatic logic [THRW-1:0] popCount(input logic [NPORT-1:0] v);
    logic [THRW-1:0] n;
    n = '0;
    for (int k = 0; k < NPORT; k++) n = n + THRW'(v[k]);
    return n;
  endfunction
endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [REGW-1:0]  regWdata,
  output logic [REGW-1:0]  regRdata,
  output trigCfg_t         cfg
);
  logic hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_SEL) cfg.selCfg <= regWdata;
      for (int i = 0; i < NMULTI; i++)
        if (regAddr == ADDRW'(ADDR_MULTI + i)) cfg.multiCfg[i] <= regWdata;
      for (int i = 0; i < NOR; i++)
        if (regAddr == ADDRW'(ADDR_OR + i)) cfg.orCfg[i] <= regWdata;
      for (int i = 0; i < NAND; i++)
        if (regAddr == ADDRW'(ADDR_AND + i)) cfg.andCfg[i] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    hit      = 1'b0;
    if (regAddr == ADDR_SEL) begin
      regRdata = cfg.selCfg;
      hit      = 1'b1;
    end
    for (int i = 0; i < NMULTI; i++)
      if (regAddr == ADDRW'(ADDR_MULTI + i)) begin
        regRdata = cfg.multiCfg[i];
        hit      = 1'b1;
      end
    for (int i = 0; i < NOR; i++)
      if (regAddr == ADDRW'(ADDR_OR + i)) begin
        regRdata = cfg.orCfg[i];
        hit      = 1'b1;
      end
    for (int i = 0; i < NAND; i++)
      if (regAddr == ADDRW'(ADDR_AND + i)) begin
        regRdata = cfg.andCfg[i];
        hit      = 1'b1;
      end
  end

  // R2: a mapped write is visible on the next read of the same address
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && hit) |=> (regAddr != $past(regAddr) || regRdata == $past(regWdata)));
  // R2: unmapped addresses read zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> regRdata == '0);
endmodule

// File: rtl/trig_levels.sv
module trig_levels
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPORT-1:0] portIn,
  input  trigCfg_t         cfg,
  output logic [NMULTI-1:0] multiQ,
  output logic [NOR-1:0]    orQ,
  output logic [NAND-1:0]   andQ,
  output logic              fpTrig
);
  logic [REGW-1:0]  orVec;
  logic [REGW-1:0]  andVec;
  logic [NTERM-1:0] terms;
  logic             fpNext;

  assign orVec  = {multiQ, portIn};
  assign andVec = {orQ, portIn};

  for (genvar i = 0; i < NMULTI; i++) begin : gMulti
    logic [THRW-1:0]  thr;
    logic [NPORT-1:0] picked;
    logic             q;
    assign thr    = cfg.multiCfg[i][REGW-1:NPORT];
    assign picked = cfg.multiCfg[i][NPORT-1:0] & portIn;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= (thr != '0) && (popCount(picked) >= thr);
    end
    assign multiQ[i] = q;
    // R4: zero threshold never fires
    assert_thr0_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
      $past(cfg.multiCfg[i][REGW-1:NPORT] == '0) |-> !multiQ[i]);
  end

  for (genvar i = 0; i < NOR; i++) begin : gOr
    logic q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= |(orVec & cfg.orCfg[i]);
    end
    assign orQ[i] = q;
    // R6: empty OR mask stays low
    assert_or_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
      $past(cfg.orCfg[i] == '0) |-> !orQ[i]);
  end

  for (genvar i = 0; i < NAND; i++) begin : gAnd
    logic [REGW-1:0] mask;
    logic            q;
    assign mask = cfg.andCfg[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= (mask != '0) && ((andVec & mask) == mask);
    end
    assign andQ[i] = q;
    // R8: empty AND mask stays low
    assert_and_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
      $past(cfg.andCfg[i] == '0) |-> !andQ[i]);
    // R7: a high AND output means every selected bit was high
    assert_and_all_R7: assert property (@(posedge clk) disable iff (!rstN)
      andQ[i] |-> $past((andVec & cfg.andCfg[i]) == cfg.andCfg[i]));
  end

  assign terms  = {andQ[NFP-1:0], orQ[NFP-1:0], multiQ[NFP-1:0], portIn};
  assign fpNext = (cfg.selCfg < REGW'(NTERM)) ? terms[cfg.selCfg[SELW-1:0]] : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fpTrig <= 1'b0;
    else       fpTrig <= fpNext;
  end

  // R10: out-of-range select code gives a quiet trigger
  assert_fp_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfg.selCfg >= REGW'(NTERM)) |-> !fpTrig);
endmodule

// File: rtl/trig_matrix.sv
module trig_matrix
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPORT-1:0]  portIn,
  input  logic              regWe,
  input  logic [ADDRW-1:0]  regAddr,
  input  logic [REGW-1:0]   regWdata,
  output logic [REGW-1:0]   regRdata,
  output logic [NMULTI-1:0] multiOut,
  output logic [NOR-1:0]    orOut,
  output logic [NAND-1:0]   andOut,
  output logic              fpTrig
);
  trigCfg_t cfg;

  trig_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .cfg      (cfg)
  );

  trig_levels u_levels (
    .clk    (clk),
    .rstN   (rstN),
    .portIn (portIn),
    .cfg    (cfg),
    .multiQ (multiOut),
    .orQ    (orOut),
    .andQ   (andOut),
    .fpTrig (fpTrig)
  );
endmodule

// File: tb/trig_matrix_bench.sv
module trig_matrix_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] portIn = '0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  multiOut;
  logic [7:0]  orOut;
  logic [1:0]  andOut;
  logic        fpTrig;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  trig_matrix u_trig_matrix (
    .clk(clk), .rstN(rstN), .portIn(portIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .multiOut(multiOut), .orOut(orOut),
    .andOut(andOut), .fpTrig(fpTrig)
  );

  // shadow configuration and expected outputs
  logic [31:0] sMulti [8];
  logic [31:0] sOr [8];
  logic [31:0] sAnd [2];
  logic [31:0] sSel;
  logic [7:0]  eMulti;
  logic [7:0]  eOr;
  logic [1:0]  eAnd;
  logic        eFp;

  function automatic logic fMul(logic [23:0] p, logic [31:0] c);
    int n = 0;
    for (int k = 0; k < 24; k++) n += int'(p[k] & c[k]);
    return (c[31:24] != 0) && (n >= int'(c[31:24]));
  endfunction

  function automatic logic fOr(logic [23:0] p, logic [7:0] m, logic [31:0] c);
    return |({m, p} & c);
  endfunction

  function automatic logic fAnd(logic [23:0] p, logic [7:0] o, logic [31:0] c);
    return (c != 0) && (({o, p} & c) == c);
  endfunction

  function automatic logic fSel(logic [23:0] p, logic [7:0] m, logic [7:0] o,
                                logic [1:0] a, logic [31:0] s);
    if (s < 24) return p[s[4:0]];
    if (s < 26) return m[s[4:0] - 5'd24];
    if (s < 28) return o[s[4:0] - 5'd26];
    if (s < 30) return a[s[4:0] - 5'd28];
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin sMulti[i] <= '0; sOr[i] <= '0; end
      sAnd[0] <= '0; sAnd[1] <= '0; sSel <= '0;
      eMulti <= '0; eOr <= '0; eAnd <= '0; eFp <= 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        eMulti[i] <= fMul(portIn, sMulti[i]);
        eOr[i]    <= fOr(portIn, eMulti, sOr[i]);
      end
      for (int i = 0; i < 2; i++) eAnd[i] <= fAnd(portIn, eOr, sAnd[i]);
      eFp <= fSel(portIn, eMulti, eOr, eAnd, sSel);
      if (regWe) begin
        if (regAddr == 8'h50) sSel <= regWdata;
        if (regAddr >= 8'h60 && regAddr <= 8'h67) sMulti[regAddr - 8'h60] <= regWdata;
        if (regAddr >= 8'h68 && regAddr <= 8'h6F) sOr[regAddr - 8'h68] <= regWdata;
        if (regAddr >= 8'h70 && regAddr <= 8'h71) sAnd[regAddr - 8'h70] <= regWdata;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R3 multiOut", 32'(multiOut), 32'(eMulti));
    check("R5 orOut", 32'(orOut), 32'(eOr));
    check("R7 andOut", 32'(andOut), 32'(eAnd));
    check("R10 fpTrig", 32'(fpTrig), 32'(eFp));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdata, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0; portIn = '0; regWe = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    // R1: reset state
    step(2);
    check("R1 multiOut in reset", 32'(multiOut), 0);
    check("R1 andOut in reset", 32'(andOut), 0);
    rstN = 1'b1;
    step(1);
    rdChk("R1 sel word", 8'h50, 0);
    rdChk("R1 multi word", 8'h65, 0);
    rdChk("R1 and word", 8'h71, 0);
    check("R1 orOut", 32'(orOut), 0);
    check("R1 fpTrig", 32'(fpTrig), 0);

    // R2: readback and unmapped address
    wrReg(8'h63, 32'hA5C3_0F11);
    rdChk("R2 readback", 8'h63, 32'hA5C3_0F11);
    wrReg(8'h63, 32'h0102_0304);
    rdChk("R2 last write", 8'h63, 32'h0102_0304);
    wrReg(8'h40, 32'hFFFF_FFFF);
    rdChk("R2 unmapped reads 0", 8'h40, 0);
    rdChk("R2 neighbour untouched", 8'h6F, 0);
    rdChk("R2 neighbour untouched", 8'h63, 32'h0102_0304);

    // R3: threshold boundary and mask
    doReset();
    wrReg(8'h61, {8'd3, 24'h00000F});
    portIn = 24'h000003; step(1);
    check("R3 below threshold", 32'(multiOut[1]), 0);
    portIn = 24'h000007; step(1);
    check("R3 at threshold", 32'(multiOut[1]), 1);
    portIn = 24'hFFFFF0; step(1);
    check("R3 unselected ports", 32'(multiOut[1]), 0);

    // R4: zero threshold
    wrReg(8'h60, {8'd0, 24'hFFFFFF});
    portIn = 24'hFFFFFF; step(2);
    check("R4 zero threshold", 32'(multiOut[0]), 0);

    // R6, R8, R7: zero masks and full AND
    doReset();
    portIn = 24'hFFFFFF;
    wrReg(8'h70, 32'h00FF_FFFF);
    step(1);
    check("R6 empty OR", 32'(orOut), 0);
    check("R8 empty AND", 32'(andOut[1]), 0);
    check("R7 all selected high", 32'(andOut[0]), 1);
    portIn = 24'hFFFDFF; step(1);
    check("R7 one selected low", 32'(andOut[0]), 0);

    // R9: chain latency
    doReset();
    wrReg(8'h60, {8'd1, 24'h000001});
    wrReg(8'h68, 32'h0100_0000);
    wrReg(8'h70, 32'h0100_0000);
    step(2);
    portIn = 24'h000001; step(1);
    check("R9 stage1 at 1", 32'({multiOut[0], orOut[0], andOut[0]}), 32'b100);
    step(1);
    check("R9 stage2 at 2", 32'({multiOut[0], orOut[0], andOut[0]}), 32'b110);
    step(1);
    check("R9 stage3 at 3", 32'({multiOut[0], orOut[0], andOut[0]}), 32'b111);

    // R10: select codes
    wrReg(8'h50, 32'd28);
    step(1);
    check("R10 code 28 AND_A", 32'(fpTrig), 1);
    wrReg(8'h50, 32'd30);
    step(1);
    check("R10 code 30 quiet", 32'(fpTrig), 0);
    wrReg(8'h50, 32'd5);
    portIn = 24'h000020; step(1);
    check("R10 code 5 port", 32'(fpTrig), 1);
    portIn = 24'h000000; step(1);
    check("R10 code 5 port low", 32'(fpTrig), 0);

    // random phase against shadow model (R3 R5 R7 R10)
    doReset();
    for (int it = 0; it < 4000; it++) begin
      int kind = $urandom % 3;
      if (kind == 0)      portIn = 24'($urandom & $urandom);
      else if (kind == 1) portIn = 24'($urandom | $urandom);
      else                portIn = 24'($urandom);
      if (($urandom % 6) == 0) begin
        int r = $urandom % 20;
        regWe = 1'b1;
        if (r < 8) begin
          regAddr = 8'(8'h60 + r);
          regWdata = {8'($urandom % 14), 24'($urandom)};
        end else if (r < 16) begin
          regAddr = 8'(8'h68 + r - 8);
          regWdata = $urandom & $urandom & $urandom;
        end else if (r < 18) begin
          regAddr = 8'(8'h70 + r - 16);
          regWdata = ($urandom % 2) ? (32'hFF00_0000 & $urandom) : ($urandom & $urandom & $urandom);
        end else if (r == 18) begin
          regAddr = 8'h50; regWdata = $urandom % 34;
        end else begin
          regAddr = 8'h3F; regWdata = $urandom;
        end
      end
      step(1);
      regWe = 1'b0;
      compareAll();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule